// File: doc/BRIEF.md
# Perspective-Corrected Span Texture Interpolator

This block produces one texture coordinate pair (u, v) for each pixel of a single horizontal span. It takes the homogeneous quantities u/w, v/w and 1/w at the first pixel, their per-pixel gradients, a pixel count and a sub-span length code. It performs an exact perspective divide only at the ends of each sub-span and fills the pixels in between by linear stepping. A longer sub-span means fewer divides and fewer output stalls, at the cost of more texture warping. A sub-span that covers the whole span reduces to plain affine mapping.

Each endpoint divide runs on a pair of 16-iteration restoring dividers, one for u and one for v. The two dividers share the 1/w divisor and operate in lockstep. While a divide is in progress the pixel output is held invalid. The step between two corrected endpoints comes from shifting their difference, because sub-span lengths are restricted to powers of two. Pixels leave through a valid/ready handshake in span order, and a last flag marks the final pixel.

Top module: `persp_span_interp`

## Requirements
- R1: After reset, `px_valid` is low and no span is active.
- R2: A `span_start` pulse is taken only when no span is active and `span_count` is non-zero. A pulse with a zero count, or a pulse during an active span, is ignored and has no effect on the pixel stream.
- R3: The corrected coordinate at pixel p is floor(h_c(p)·256 / h_w(p)), an unsigned value with 8 fractional bits. Here h(p) = base + p·gradient modulo 2^16, and gradients are 16-bit two's complement. The result is 0xFFFF when h_w(p) is zero or the quotient is 2^16 or more.
- R4: Every pixel whose index is a multiple of the sub-span length L, counting from 0, carries the exact corrected coordinate of R3.
- R5: Pixel s+j inside the sub-span starting at s (0 < j < L) equals c(s) + floor(j·(c(s+L) − c(s)) / L).
- R6: `sub_shift` code k selects L = 2^k for k from 0 to 5. Codes 6 and 7 behave as code 5 (L = 32).
- R7: A final sub-span that holds fewer than L pixels stops at pixel N−1. Its slope is still taken from the divide at position s+L.
- R8: Exactly N pixels are delivered in index order. `px_last` is high on the final pixel only, and `px_valid` drops in the cycle after that pixel is accepted.
- R9: While `px_valid` is high and `px_ready` is low, `px_valid`, `px_u`, `px_v` and `px_last` hold steady.
- R10: `px_valid` first rises 36 cycles (two divides of 18 cycles) after the edge that accepts the start. Each accepted pixel at a sub-span end with pixels still remaining is followed by exactly 18 cycles of `px_valid` low. No other bubble appears while `px_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| span_start | input | 1 | Pulse that begins a span when idle |
| span_count | input | 10 | Number of pixels N in the span |
| sub_shift | input | 3 | Sub-span length code k, L = 2^min(k,5) |
| uw0 | input | 16 | u/w at pixel 0, unsigned |
| vw0 | input | 16 | v/w at pixel 0, unsigned |
| iw0 | input | 16 | 1/w at pixel 0, unsigned |
| duw | input | 16 | Per-pixel gradient of u/w, two's complement |
| dvw | input | 16 | Per-pixel gradient of v/w, two's complement |
| diw | input | 16 | Per-pixel gradient of 1/w, two's complement |
| px_valid | output | 1 | A pixel coordinate is presented |
| px_ready | input | 1 | Consumer accepts the presented pixel |
| px_u | output | 16 | u coordinate, 8 fractional bits |
| px_v | output | 16 | v coordinate, 8 fractional bits |
| px_last | output | 1 | Presented pixel is the final one of the span |

## Verification
The assertions assume that the homogeneous values stay inside their 16-bit range and that 1/w remains positive from pixel 0 out to N−1+L, including the extrapolated endpoint past the span. They also assume the consumer follows the valid/ready rules. The stimulus picks bases and gradients that keep every sampled position inside that range. It only asserts `span_start` either while idle or as a deliberate mid-span pulse to confirm that such a pulse is ignored. Saturation is covered by a span whose quotient overflows and whose 1/w reaches zero. The checks compare against a reference that computes the expected results exactly as R3 and R5 define them.

// File: rtl/span_pkg.sv
package span_pkg;
   localparam int HOM_W     = 16;
   localparam int FRAC_W    = 8;
   localparam int CRD_W     = 16;
   localparam int MAX_SHIFT = 5;
   localparam int CNT_W     = 10;
   localparam int SHF_W     = 3;
   localparam int N_HOM     = 3;
   localparam int N_CRD     = 2;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LOAD,
      ST_WAIT,
      ST_EMIT
   } span_state_e;

   typedef enum logic [1:0] {
      PH_ORIGIN,
      PH_FIRST_END,
      PH_NEXT_END
   } span_phase_e;
endpackage

// File: rtl/span_div.sv
module span_div #(
   parameter int NUM_W = 24,
   parameter int DEN_W = 16,
   parameter int QUO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic             busy,
   output logic             done,
   output logic [QUO_W-1:0] quo
);
   localparam int UP_W  = NUM_W - QUO_W;
   localparam int CNT_W = $clog2(QUO_W + 1);
   localparam int PRD_W = NUM_W + DEN_W + 1;

   initial begin
      if (UP_W < 1 || UP_W > DEN_W) $fatal(1, "span_div: numerator width out of range");
   end

   logic [DEN_W-1:0] rem_q;
   logic [DEN_W-1:0] den_q;
   logic [QUO_W-1:0] low_q;
   logic [NUM_W-1:0] num_q;
   logic [CNT_W-1:0] cnt_q;
   logic             sat_q;
   logic             done_q;
   logic [DEN_W:0]   trial;
   logic             fits;

   always_comb begin
      trial = {rem_q, low_q[QUO_W-1]};
      fits  = (trial >= {1'b0, den_q});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         den_q  <= '0;
         low_q  <= '0;
         num_q  <= '0;
         cnt_q  <= '0;
         sat_q  <= 1'b0;
         done_q <= 1'b0;
      end else if (go) begin
         rem_q  <= DEN_W'(num[NUM_W-1:QUO_W]);
         low_q  <= num[QUO_W-1:0];
         den_q  <= den;
         num_q  <= num;
         sat_q  <= (DEN_W'(num[NUM_W-1:QUO_W]) >= den);
         cnt_q  <= CNT_W'(QUO_W);
         done_q <= 1'b0;
      end else if (cnt_q != '0) begin
         rem_q  <= fits ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
         low_q  <= {low_q[QUO_W-2:0], fits};
         cnt_q  <= cnt_q - 1'b1;
         done_q <= (cnt_q == CNT_W'(1));
      end else begin
         done_q <= 1'b0;
      end
   end

   assign busy = (cnt_q != '0);
   assign done = done_q;
   assign quo  = sat_q ? '1 : low_q;

   // quotient brackets the dividend exactly (R3)
   logic [PRD_W-1:0] prod_lo;
   logic [PRD_W-1:0] prod_hi;
   always_comb begin
      prod_lo = PRD_W'(low_q) * PRD_W'(den_q);
      prod_hi = prod_lo + PRD_W'(den_q);
   end

   assert_div_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done && !sat_q |-> (prod_lo <= PRD_W'(num_q)) && (prod_hi > PRD_W'(num_q)));

   assert_div_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> !busy);
endmodule

// File: rtl/span_homog.sv
module span_homog #(
   parameter int HOM_W = 16,
   parameter int POS_W = 11
) (
   input  logic [HOM_W-1:0] base,
   input  logic [HOM_W-1:0] grad,
   input  logic [POS_W-1:0] pos,
   output logic [HOM_W-1:0] val
);
   initial begin
      if (POS_W > HOM_W) $fatal(1, "span_homog: position wider than value");
   end

   // modulo-2^HOM_W evaluation; low product bits match the signed product
   always_comb val = base + grad * HOM_W'(pos);
endmodule

// File: rtl/span_step.sv
module span_step #(
   parameter int CRD_W     = 16,
   parameter int MAX_SHIFT = 5,
   parameter int SHF_W     = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_origin,
   input  logic             set_end,
   input  logic             fresh,
   input  logic             advance,
   input  logic [SHF_W-1:0] shift,
   input  logic [CRD_W-1:0] quo,
   output logic [CRD_W-1:0] coord
);
   localparam int ACC_W = CRD_W + MAX_SHIFT;
   localparam logic [SHF_W-1:0] MAXS = SHF_W'(MAX_SHIFT);

   logic [CRD_W-1:0] anchor_q;
   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] step_q;
   logic [ACC_W-1:0] diff_ext;
   logic [ACC_W-1:0] step_new;
   logic [ACC_W-1:0] anchor_ext;

   always_comb begin
      diff_ext   = ACC_W'(quo) - ACC_W'(anchor_q);
      step_new   = diff_ext << (MAXS - shift);
      anchor_ext = {anchor_q, {MAX_SHIFT{1'b0}}};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         anchor_q <= '0;
         acc_q    <= '0;
         step_q   <= '0;
      end else if (set_origin) begin
         anchor_q <= quo;
      end else if (set_end) begin
         step_q   <= step_new;
         anchor_q <= quo;
         acc_q    <= anchor_ext + (fresh ? ACC_W'(0) : step_new);
      end else if (advance) begin
         acc_q    <= acc_q + step_q;
      end
   end

   assign coord = acc_q[ACC_W-1:MAX_SHIFT];

   // a fresh sub-span starts on the origin value (R4)
   assert_fresh_origin_R4: assert property (@(posedge clk) disable iff (!rst_n)
      set_end && fresh |=> coord == $past(anchor_q));
endmodule

// File: rtl/persp_span_interp.sv
module persp_span_interp
   import span_pkg::*;
#(
   parameter int P_HOM_W     = HOM_W,
   parameter int P_FRAC_W    = FRAC_W,
   parameter int P_CRD_W     = CRD_W,
   parameter int P_MAX_SHIFT = MAX_SHIFT,
   parameter int P_CNT_W     = CNT_W,
   parameter int P_SHF_W     = SHF_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 span_start,
   input  logic [P_CNT_W-1:0]   span_count,
   input  logic [P_SHF_W-1:0]   sub_shift,
   input  logic [P_HOM_W-1:0]   uw0,
   input  logic [P_HOM_W-1:0]   vw0,
   input  logic [P_HOM_W-1:0]   iw0,
   input  logic [P_HOM_W-1:0]   duw,
   input  logic [P_HOM_W-1:0]   dvw,
   input  logic [P_HOM_W-1:0]   diw,
   output logic                 px_valid,
   input  logic                 px_ready,
   output logic [P_CRD_W-1:0]   px_u,
   output logic [P_CRD_W-1:0]   px_v,
   output logic                 px_last
);
   localparam int POS_W = P_CNT_W + 1;
   localparam int NUM_W = P_HOM_W + P_FRAC_W;
   localparam int SEG_W = P_MAX_SHIFT + 1;
   localparam logic [P_SHF_W-1:0] MAXS = P_SHF_W'(P_MAX_SHIFT);

   initial begin
      if (P_MAX_SHIFT >= P_CNT_W) $fatal(1, "persp_span_interp: sub-span longer than count range");
      if (P_MAX_SHIFT >= (1 << P_SHF_W)) $fatal(1, "persp_span_interp: shift code too narrow");
   end

   span_state_e state_q;
   span_phase_e phase_q;
   logic [P_CNT_W-1:0] count_q;
   logic [P_CNT_W-1:0] pix_q;
   logic [P_SHF_W-1:0] shift_q;
   logic [SEG_W-1:0]   seg_j_q;
   logic [POS_W-1:0]   target_q;
   logic [N_HOM-1:0][P_HOM_W-1:0] base_q;
   logic [N_HOM-1:0][P_HOM_W-1:0] grad_q;

   logic [P_SHF_W-1:0] shift_in;
   logic [SEG_W-1:0]   seg_len;
   logic               at_last;
   logic               div_go;
   logic               div_done;
   logic               set_origin;
   logic               set_end;
   logic               fresh;
   logic               advance;

   logic [N_HOM-1:0][P_HOM_W-1:0] hom;
   logic [N_CRD-1:0][P_CRD_W-1:0] quo;
   logic [N_CRD-1:0][P_CRD_W-1:0] coord;
   logic [N_CRD-1:0]              dv_busy;
   logic [N_CRD-1:0]              dv_done;

   always_comb begin
      shift_in   = (sub_shift > MAXS) ? MAXS : sub_shift;
      seg_len    = SEG_W'(1) << shift_q;
      at_last    = (pix_q == count_q - 1'b1);
      div_go     = (state_q == ST_LOAD);
      div_done   = dv_done[0];
      set_origin = (state_q == ST_WAIT) && div_done && (phase_q == PH_ORIGIN);
      set_end    = (state_q == ST_WAIT) && div_done && (phase_q != PH_ORIGIN);
      fresh      = (phase_q == PH_FIRST_END);
      advance    = (state_q == ST_EMIT) && px_ready && !at_last && (seg_j_q < seg_len);
   end

   // homogeneous evaluators: index 0 = u/w, 1 = v/w, 2 = 1/w
   generate
      for (genvar h = 0; h < N_HOM; h++) begin : g_hom
         span_homog #(.HOM_W(P_HOM_W), .POS_W(POS_W)) u_hom (
            .base (base_q[h]),
            .grad (grad_q[h]),
            .pos  (target_q),
            .val  (hom[h])
         );
      end

      for (genvar c = 0; c < N_CRD; c++) begin : g_crd
         span_div #(.NUM_W(NUM_W), .DEN_W(P_HOM_W), .QUO_W(P_CRD_W)) u_div (
            .clk  (clk),
            .rst_n(rst_n),
            .go   (div_go),
            .num  ({hom[c], {P_FRAC_W{1'b0}}}),
            .den  (hom[2]),
            .busy (dv_busy[c]),
            .done (dv_done[c]),
            .quo  (quo[c])
         );

         span_step #(.CRD_W(P_CRD_W), .MAX_SHIFT(P_MAX_SHIFT), .SHF_W(P_SHF_W)) u_step (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_origin(set_origin),
            .set_end   (set_end),
            .fresh     (fresh),
            .advance   (advance),
            .shift     (shift_q),
            .quo       (quo[c]),
            .coord     (coord[c])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         phase_q  <= PH_ORIGIN;
         count_q  <= '0;
         pix_q    <= '0;
         shift_q  <= '0;
         seg_j_q  <= '0;
         target_q <= '0;
         base_q   <= '0;
         grad_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (span_start && (span_count != '0)) begin
                  count_q  <= span_count;
                  shift_q  <= shift_in;
                  base_q   <= {iw0, vw0, uw0};
                  grad_q   <= {diw, dvw, duw};
                  pix_q    <= '0;
                  target_q <= '0;
                  phase_q  <= PH_ORIGIN;
                  state_q  <= ST_LOAD;
               end
            end
            ST_LOAD: state_q <= ST_WAIT;
            ST_WAIT: begin
               if (div_done) begin
                  unique case (phase_q)
                     PH_ORIGIN: begin
                        phase_q  <= PH_FIRST_END;
                        target_q <= POS_W'(seg_len);
                        state_q  <= ST_LOAD;
                     end
                     PH_FIRST_END: begin
                        phase_q <= PH_NEXT_END;
                        seg_j_q <= '0;
                        state_q <= ST_EMIT;
                     end
                     default: begin
                        seg_j_q <= SEG_W'(1);
                        state_q <= ST_EMIT;
                     end
                  endcase
               end
            end
            ST_EMIT: begin
               if (px_ready) begin
                  if (at_last) begin
                     state_q <= ST_IDLE;
                  end else begin
                     pix_q <= pix_q + 1'b1;
                     if (seg_j_q < seg_len) begin
                        seg_j_q <= seg_j_q + 1'b1;
                     end else begin
                        target_q <= POS_W'(pix_q) + POS_W'(seg_len);
                        state_q  <= ST_LOAD;
                     end
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign px_valid = (state_q == ST_EMIT);
   assign px_u     = coord[0];
   assign px_v     = coord[1];
   assign px_last  = px_valid && at_last;

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      px_valid && !px_ready |=> px_valid && $stable(px_u) && $stable(px_v) && $stable(px_last));

   assert_quiet_divide_R10: assert property (@(posedge clk) disable iff (!rst_n)
      dv_busy[0] |-> !px_valid);

   assert_lockstep_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (dv_done[0] == dv_done[1]) && (dv_busy[0] == dv_busy[1]));

   assert_last_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
      px_valid && px_ready && px_last |=> !px_valid);

   assert_pix_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      px_valid |-> pix_q < count_q);

   assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) && span_start |=> $stable(count_q) && $stable(shift_q));
endmodule

// File: tb/persp_span_interp_bench.sv
module persp_span_interp_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DIV_CYC    = 18;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        span_start = 1'b0;
   logic [9:0]  span_count = '0;
   logic [2:0]  sub_shift = '0;
   logic [15:0] uw0 = '0, vw0 = '0, iw0 = '0, duw = '0, dvw = '0, diw = '0;
   logic        px_ready = 1'b0;
   logic        px_valid, px_last;
   logic [15:0] px_u, px_v;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   persp_span_interp u_persp_span_interp (
      .clk(clk), .rst_n(rst_n), .span_start(span_start), .span_count(span_count),
      .sub_shift(sub_shift), .uw0(uw0), .vw0(vw0), .iw0(iw0), .duw(duw), .dvw(dvw),
      .diw(diw), .px_valid(px_valid), .px_ready(px_ready), .px_u(px_u), .px_v(px_v),
      .px_last(px_last)
   );

   task automatic check(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int hom(int b, int g, int p);
      return (b + g * p) & 32'hFFFF;
   endfunction

   function automatic int corr(int hb, int hg, int wb, int wg, int p);
      int hc;
      int hw;
      longint num;
      hc  = hom(hb, hg, p);
      hw  = hom(wb, wg, p);
      num = longint'(hc) * 256;
      if (hw == 0) return 65535;
      if (num / hw >= 65536) return 65535;
      return int'(num / hw);
   endfunction

   function automatic int expect_px(int i, int k, int hb, int hg, int wb, int wg);
      int l;
      int s;
      int j;
      int c0;
      int c1;
      longint t;
      l  = 1 << k;
      s  = (i / l) * l;
      j  = i - s;
      c0 = corr(hb, hg, wb, wg, s);
      c1 = corr(hb, hg, wb, wg, s + l);
      t  = longint'(j) * longint'(c1 - c0);
      return c0 + int'(t >>> k);
   endfunction

   // one span: stall_mode 1 drops ready every third cycle, poke issues a mid-span start
   task automatic run_span(string tag, int n, int code, int u0, int du, int v0, int dv,
                           int w0, int dw, bit stall_mode, bit poke);
      int  k;
      int  got;
      int  lat;
      int  low_cnt;
      int  cyc;
      bit  seen;
      bit  hold;
      int  hu, hv, hl;
      k = (code > 5) ? 5 : code;
      @(negedge clk);
      span_count = 10'(n); sub_shift = 3'(code);
      uw0 = 16'(u0); duw = 16'(du); vw0 = 16'(v0); dvw = 16'(dv);
      iw0 = 16'(w0); diw = 16'(dw);
      span_start = 1'b1;
      @(negedge clk);
      span_start = 1'b0;
      got = 0; lat = 0; low_cnt = 0; cyc = 0; seen = 1'b0; hold = 1'b0;
      hu = 0; hv = 0; hl = 0;
      while (got < n && cyc < 20000) begin
         px_ready = stall_mode ? ((cyc % 3) != 1) : 1'b1;
         if (poke && cyc == 60) begin
            span_start = 1'b1; span_count = 10'd3; sub_shift = 3'd0;
            uw0 = 16'h0100; iw0 = 16'h0100;
         end else begin
            span_start = 1'b0;
         end
         #1;
         if (hold) begin
            check(px_valid && px_u == 16'(hu) && px_v == 16'(hv) && px_last == hl[0],
                  "R9", {tag, " held u"}, int'(px_u), hu);
         end
         if (px_valid) begin
            seen = 1'b1;
            if (px_ready) begin
               check(int'(px_u) == expect_px(got, k, u0, du, w0, dw), "R5",
                     $sformatf("%s u pixel %0d", tag, got), int'(px_u),
                     expect_px(got, k, u0, du, w0, dw));
               check(int'(px_v) == expect_px(got, k, v0, dv, w0, dw), "R5",
                     $sformatf("%s v pixel %0d", tag, got), int'(px_v),
                     expect_px(got, k, v0, dv, w0, dw));
               check(px_last == (got == n - 1), "R8",
                     $sformatf("%s last flag pixel %0d", tag, got), int'(px_last),
                     int'(got == n - 1));
               got++;
               hold = 1'b0;
            end else begin
               hold = 1'b1; hu = int'(px_u); hv = int'(px_v); hl = int'(px_last);
            end
         end else begin
            if (!seen) lat++;
            else low_cnt++;
            hold = 1'b0;
         end
         @(negedge clk);
         cyc++;
      end
      span_start = 1'b0;
      check(got == n, "R8", {tag, " pixel count"}, got, n);
      check(lat == 2 * DIV_CYC, "R10", {tag, " first pixel latency"}, lat, 2 * DIV_CYC);
      check(low_cnt == ((n >= 2) ? DIV_CYC * ((n - 2) / (1 << k)) : 0), "R10",
            {tag, " divide stall cycles"}, low_cnt,
            (n >= 2) ? DIV_CYC * ((n - 2) / (1 << k)) : 0);
      #1;
      check(!px_valid, "R8", {tag, " valid drops after last"}, int'(px_valid), 0);
      if (poke) begin
         repeat (60) @(negedge clk);
         #1;
         check(!px_valid, "R2", {tag, " mid-span start ignored"}, int'(px_valid), 0);
      end
   endtask

   task automatic test_reset();
      #1;
      check(!px_valid, "R1", "valid during reset", int'(px_valid), 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      #1;
      check(!px_valid, "R1", "valid after reset", int'(px_valid), 0);
   endtask

   task automatic test_zero_count();
      int seen_valid;
      seen_valid = 0;
      @(negedge clk);
      span_count = 10'd0; sub_shift = 3'd2; uw0 = 16'h1000; iw0 = 16'h1000;
      span_start = 1'b1;
      @(negedge clk);
      span_start = 1'b0;
      repeat (50) begin
         #1;
         if (px_valid) seen_valid++;
         @(negedge clk);
      end
      check(seen_valid == 0, "R2", "zero-count start ignored", seen_valid, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      test_reset();
      // R3 R4 R5: perspective span, L = 4
      run_span("R4_base", 16, 2, 'h3000, 'h0100, 'h1000, -'h40, 'h4000, -'h80, 1'b0, 1'b0);
      // R4: every pixel exact, L = 1
      run_span("R4_exact", 9, 0, 'h2400, 'h0180, 'h0800, 'h0090, 'h3000, -'h100, 1'b0, 1'b0);
      // R5: single sub-span, affine
      run_span("R5_affine", 9, 3, 'h5000, -'h0200, 'h0400, 'h0300, 'h2000, 'h0180, 1'b0, 1'b0);
      // R7: final sub-span shorter than L
      run_span("R7_partial", 11, 2, 'h3000, 'h0100, 'h2000, 'h0050, 'h4000, -'h180, 1'b0, 1'b0);
      // R6: code 7 behaves as L = 32
      run_span("R6_clamp", 40, 7, 'h2000, 'h0040, 'h1000, 'h0020, 'h4000, -'h80, 1'b0, 1'b0);
      // R9 R2: backpressure and ignored mid-span start
      run_span("R9_stall", 20, 1, 'h3000, 'h0100, 'h1000, 'h0040, 'h4000, -'h80, 1'b1, 1'b1);
      // R8: single pixel span
      run_span("R8_single", 1, 2, 'h1234, 'h0010, 'h0567, 'h0020, 'h2000, 'h0010, 1'b0, 1'b0);
      // R3: saturation on overflow and on zero 1/w
      run_span("R3_sat", 6, 1, 'h8000, 'h0000, 'h4000, 'h0000, 'h0010, -'h10, 1'b0, 1'b0);
      test_zero_count();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule